// File: doc/BRIEF.md
# Stateful Reply Port Filter

This block decides whether an inbound TCP segment is an expected reply. When the host opens a connection, the block captures the outbound source port and starts an elapsed-time counter. A prescaler paces this counter by emitting one tick every `TICK_DIV` system clocks. When an inbound segment's destination port is presented, the block judges it. The port is accepted if it is one of a few fixed service ports. It is also accepted if it equals the captured port while the response window is still open. In any other case the segment is marked for discard.

The verdict is a registered two-bit code that comes with a one-cycle valid pulse. The inbound port that the verdict refers to is registered beside it. Only one outbound connection is tracked at a time. A new outbound request replaces the previous one and restarts the window. The window length is an input, `window_len`, counted in prescaler ticks.

Top module: `pkt_port_filter`

## Requirements
- R1: After a synchronous active-high reset, `verdict` is 2'b00 (initial) and `verdict_vld` is 0. No port is held, so a non-service inbound port is judged 2'b11 (protect).
- R2: Each cycle with `in_stb` high yields exactly one `verdict_vld` pulse in the following cycle. In that cycle `verdict_port` equals the inbound port. `verdict_vld` stays low in the cycle after any cycle with `in_stb` low.
- R3: Inbound ports 53, 80 and 443 are judged 2'b01 (normal) in every state: with no request, with a held port, and after timeout.
- R4: A non-service inbound port that equals the held outbound port is judged 2'b01 while the window is open.
- R5: A non-service inbound port that differs from the held port is judged 2'b11 (protect). So is any non-service port when no request has been made since reset.
- R6: The elapsed count is 0 after a request and rises by one every `TICK_DIV` clocks. It saturates at its maximum. Once it is at least `window_len`, the held port is dropped. Every non-service inbound port, including the old matching one, is then judged 2'b10 (time over) until the next request.
- R7: A new outbound request replaces the held port and restarts both the elapsed count and the prescaler phase.
- R8: `verdict` holds its value in every cycle that does not follow an inbound strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| out_stb | input | 1 | Outbound request strobe, one cycle |
| out_src_port | input | 16 | Source port of the outbound request |
| in_stb | input | 1 | Inbound segment strobe, one cycle per segment |
| in_dst_port | input | 16 | Destination port of the inbound segment |
| window_len | input | 8 | Response window length in prescaler ticks |
| verdict | output | 2 | 00 initial, 01 normal, 10 time over, 11 protect |
| verdict_vld | output | 1 | One-cycle pulse marking a fresh verdict |
| verdict_port | output | 16 | Inbound port the current verdict applies to |

## Verification
The assertions assume two things about the inputs. First, `out_stb` and `in_stb` are never high in the same cycle. Second, `window_len` does not change while a request is being timed. Under these conditions the elapsed count only rises between requests, and a verdict follows each strobe by exactly one cycle. The stimulus separates the two strobe kinds in time. It changes `window_len` only before issuing a fresh request. The bench's reference model counts clock edges from each request and converts them to ticks using the same prescaler ratio.

// File: rtl/pf_pkg.sv
package pf_pkg;

  localparam int PORT_W = 16;
  localparam int N_SVC  = 3;

  typedef enum logic [1:0] {
    V_INIT     = 2'b00,
    V_NORMAL   = 2'b01,
    V_TIMEOVER = 2'b10,
    V_PROTECT  = 2'b11
  } verdict_e;

  localparam logic [PORT_W-1:0] SVC_PORTS [N_SVC] = '{16'd53, 16'd80, 16'd443};

  function automatic logic is_service_port(input logic [PORT_W-1:0] p);
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < N_SVC; i++) begin
      if (p == SVC_PORTS[i]) hit = 1'b1;
    end
    return hit;
  endfunction

  function automatic logic window_shut(input logic [7:0] elapsed, input logic [7:0] limit);
    return elapsed >= limit;
  endfunction

  // priority: service port, then closed window, then port equality
  function automatic verdict_e decide(input logic svc, input logic shut, input logic same);
    if (svc)       return V_NORMAL;
    else if (shut) return V_TIMEOVER;
    else if (same) return V_NORMAL;
    else           return V_PROTECT;
  endfunction

endpackage

// File: rtl/pf_tick_gen.sv
module pf_tick_gen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] phase;

  assign tick = (phase == LAST);

  always_ff @(posedge clk) begin
    if (rst || restart)  phase <= '0;
    else if (tick)       phase <= '0;
    else                 phase <= phase + 1'b1;
  end

  assert_phase_in_range_R6: assert property (@(posedge clk) disable iff (rst)
    phase <= LAST);

endmodule

// File: rtl/pf_conn_track.sv
module pf_conn_track
  import pf_pkg::*;
#(
  parameter int TIME_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_stb,
  input  logic [PORT_W-1:0] req_port,
  input  logic              tick,
  input  logic [TIME_W-1:0] limit,
  output logic [PORT_W-1:0] held_port,
  output logic              held_valid,
  output logic              timed_out
);
  localparam logic [TIME_W-1:0] T_MAX = '1;

  logic [TIME_W-1:0] elapsed;
  logic              expired;
  logic              expire_now;

  assign expire_now = held_valid && window_shut(8'(elapsed), 8'(limit));
  assign timed_out  = expired || expire_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_port  <= '0;
      held_valid <= 1'b0;
      expired    <= 1'b0;
      elapsed    <= '0;
    end else if (req_stb) begin
      held_port  <= req_port;
      held_valid <= 1'b1;
      expired    <= 1'b0;
      elapsed    <= '0;
    end else begin
      if (tick && elapsed != T_MAX) elapsed <= elapsed + 1'b1;
      if (expire_now) begin
        held_port  <= '0;
        held_valid <= 1'b0;
        expired    <= 1'b1;
      end
    end
  end

  assert_elapsed_no_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    !req_stb |=> elapsed >= $past(elapsed));

  assert_expiry_drops_port_R6: assert property (@(posedge clk) disable iff (rst)
    (expire_now && !req_stb) |=> (!held_valid && expired));

  assert_request_restarts_R7: assert property (@(posedge clk) disable iff (rst)
    req_stb |=> (held_valid && elapsed == '0 && held_port == $past(req_port)));

endmodule

// File: rtl/pf_judge.sv
module pf_judge
  import pf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_stb,
  input  logic [PORT_W-1:0] in_port,
  input  logic [PORT_W-1:0] held_port,
  input  logic              held_valid,
  input  logic              timed_out,
  output logic [1:0]        verdict,
  output logic              verdict_vld,
  output logic [PORT_W-1:0] verdict_port
);
  logic     svc_hit;
  logic     port_same;
  verdict_e next_v;

  assign svc_hit   = is_service_port(in_port);
  assign port_same = held_valid && (in_port == held_port);
  assign next_v    = decide(svc_hit, timed_out, port_same);

  always_ff @(posedge clk) begin
    if (rst) begin
      verdict      <= V_INIT;
      verdict_vld  <= 1'b0;
      verdict_port <= '0;
    end else begin
      verdict_vld <= in_stb;
      if (in_stb) begin
        verdict      <= next_v;
        verdict_port <= in_port;
      end
    end
  end

  assert_pulse_follows_R2: assert property (@(posedge clk) disable iff (rst)
    in_stb |=> verdict_vld);

  assert_no_stray_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    !in_stb |=> !verdict_vld);

  assert_service_accepted_R3: assert property (@(posedge clk) disable iff (rst)
    (in_stb && svc_hit) |=> verdict == V_NORMAL);

  assert_verdict_held_R8: assert property (@(posedge clk) disable iff (rst)
    !verdict_vld |-> $stable(verdict));

endmodule

// File: rtl/pkt_port_filter.sv
module pkt_port_filter
  import pf_pkg::*;
#(
  parameter int TIME_W   = 8,
  parameter int TICK_DIV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              out_stb,
  input  logic [15:0]       out_src_port,
  input  logic              in_stb,
  input  logic [15:0]       in_dst_port,
  input  logic [TIME_W-1:0] window_len,
  output logic [1:0]        verdict,
  output logic              verdict_vld,
  output logic [15:0]       verdict_port
);
  logic              tick;
  logic [PORT_W-1:0] held_port;
  logic              held_valid;
  logic              timed_out;

  pf_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk     (clk),
    .rst     (rst),
    .restart (out_stb),
    .tick    (tick)
  );

  pf_conn_track #(.TIME_W(TIME_W)) u_track (
    .clk        (clk),
    .rst        (rst),
    .req_stb    (out_stb),
    .req_port   (out_src_port),
    .tick       (tick),
    .limit      (window_len),
    .held_port  (held_port),
    .held_valid (held_valid),
    .timed_out  (timed_out)
  );

  pf_judge u_judge (
    .clk          (clk),
    .rst          (rst),
    .in_stb       (in_stb),
    .in_port      (in_dst_port),
    .held_port    (held_port),
    .held_valid   (held_valid),
    .timed_out    (timed_out),
    .verdict      (verdict),
    .verdict_vld  (verdict_vld),
    .verdict_port (verdict_port)
  );

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (verdict == V_INIT && !verdict_vld));

endmodule

// File: tb/pkt_port_filter_tb.sv
module pkt_port_filter_tb;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        out_stb = 1'b0;
  logic [15:0] out_src_port = '0;
  logic        in_stb = 1'b0;
  logic [15:0] in_dst_port = '0;
  logic [7:0]  window_len = 8'd3;
  logic [1:0]  verdict;
  logic        verdict_vld;
  logic [15:0] verdict_port;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [1:0]  exp_v_q[$];
  logic [15:0] exp_p_q[$];
  string       exp_tag_q[$];

  // reference model state
  bit          m_has_req = 1'b0;
  logic [15:0] m_port = '0;
  int          m_edges = 0;

  always #10 clk = ~clk;

  pkt_port_filter #(.TIME_W(8), .TICK_DIV(DIV)) u_dut (
    .clk(clk), .rst(rst), .out_stb(out_stb), .out_src_port(out_src_port),
    .in_stb(in_stb), .in_dst_port(in_dst_port), .window_len(window_len),
    .verdict(verdict), .verdict_vld(verdict_vld), .verdict_port(verdict_port)
  );

  function automatic logic [1:0] model(input logic [15:0] p);
    int ticks;
    ticks = m_edges / DIV;
    if (ticks > 255) ticks = 255;
    if (p == 16'd53 || p == 16'd80 || p == 16'd443) return 2'b01;
    if (m_has_req && ticks >= int'(window_len)) return 2'b10;
    if (m_has_req && p == m_port) return 2'b01;
    return 2'b11;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
    m_edges += k;
  endtask

  task automatic request(input logic [15:0] p);
    out_stb = 1'b1;
    out_src_port = p;
    @(negedge clk);
    out_stb = 1'b0;
    m_has_req = 1'b1;
    m_port = p;
    m_edges = 0;
  endtask

  task automatic reply(input logic [15:0] p, input string tag);
    in_stb = 1'b1;
    in_dst_port = p;
    exp_v_q.push_back(model(p));
    exp_p_q.push_back(p);
    exp_tag_q.push_back(tag);
    @(negedge clk);
    in_stb = 1'b0;
    m_edges += 1;
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && verdict_vld) begin
        if (exp_v_q.size() == 0) begin
          check("R2 unexpected pulse", 32'(verdict_vld), 32'd0);
        end else begin
          string t;
          t = exp_tag_q.pop_front();
          check(t, 32'(verdict), 32'(exp_v_q.pop_front()));
          check({"R2 port ", t}, 32'(verdict_port), 32'(exp_p_q.pop_front()));
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [1:0] held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset verdict", 32'(verdict), 32'd0);
    check("R1 reset pulse", 32'(verdict_vld), 32'd0);
    idle(2);

    // no request yet
    reply(16'h1234, "R1 R5 no request protect");
    reply(16'd53, "R3 service dns idle");

    // window of 3 ticks
    window_len = 8'd3;
    request(16'hC001);
    reply(16'hC001, "R4 match open window");
    reply(16'hC002, "R5 mismatch protect");
    reply(16'd443, "R3 service https");
    idle(11 - m_edges);
    reply(16'hC001, "R4 match last open tick");
    reply(16'hC001, "R6 match after timeout");
    reply(16'd80, "R3 service during timeout");
    reply(16'h1111, "R6 other after timeout");

    // hold between verdicts
    held = verdict;
    idle(5);
    check("R8 verdict held", 32'(verdict), 32'(held));
    check("R2 no pulse when idle", 32'(verdict_vld), 32'd0);

    // restart on new request
    request(16'hD000);
    idle(10);
    request(16'hD100);
    idle(10);
    reply(16'hD000, "R7 old port replaced");
    reply(16'hD100, "R7 restarted window");

    // long window saturates and still times out
    window_len = 8'd255;
    request(16'hE000);
    idle(200);
    reply(16'hE000, "R4 long window open");
    idle(1100);
    reply(16'hE000, "R6 saturated timeout");

    // zero window
    window_len = 8'd0;
    request(16'hF00D);
    reply(16'hF00D, "R6 zero window");
    reply(16'd53, "R3 service zero window");

    idle(4);
    check("R2 all verdicts seen", 32'(exp_v_q.size()), 32'd0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule